// File: doc/BRIEF.md
# Multi-Mode Right-Core Shift Unit

This block shifts or rotates a data word by a binary-coded amount in a single clock cycle and registers the result. All movement comes from one right-rotate network. A left move by `m` places is done as a right rotate by `n-m`. Bits that wrap around the end of the word are then replaced by a fill value, except in the circular mode, where the wrapped bits are kept.

The operation select picks one of three modes:
- **Logical:** the freed positions take a constant zero, a constant one, or bits from a stream word.
- **Arithmetic:** a right move copies the sign bit into the freed positions. A left move fills with zeros.
- **Circular:** nothing is lost; bits leaving one end re-enter at the other.

The result is available on the output one clock edge after the inputs are sampled.

Top module: `shift_unit`

## Requirements
- R1: While reset is active, and after reset, until the first operation is captured, `dout` reads all zeros.
- R2: Logical right shift by m with zero fill (`op_sel`=0, `fill_sel`=0) gives `din >> m`.
- R3: Logical fill with `fill_sel`=1 puts ones in every freed position, for both directions.
- R4: With `fill_sel`=2 on a right shift by m, freed bit `n-m+i` takes `fill_stream[i]` (stream consumed LSB first).
- R5: Logical left shift by m gives `din << m`. With `fill_sel`=2, freed bit `i` (for i < m) takes `fill_stream[i]`.
- R6: Arithmetic right shift (`op_sel`=1, `dir_left`=0) copies `din[n-1]` into the m freed upper positions.
- R7: Arithmetic left shift equals a zero-filled logical left shift, whatever `fill_sel` holds.
- R8: Circular mode (`op_sel`=2) rotates right by m, or left by m when `dir_left`=1; no bit is lost.
- R9: An amount of 0 passes `din` unchanged in every mode and direction.
- R10: The largest amount, n-1, is handled in every mode: one bit survives and n-1 positions are filled or rotated.
- R11: `op_sel`=3 acts as logical mode, and `fill_sel`=3 acts as zero fill.
- R12: `dout` shows the result of the inputs sampled at the previous rising clock edge; back-to-back operations give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; internally released in step with the clock |
| din | input | W | Data word to be moved |
| amt | input | $clog2(W) | Binary shift amount, 0 to W-1 |
| dir_left | input | 1 | 1 = left, 0 = right |
| op_sel | input | 2 | 0 logical, 1 arithmetic, 2 circular, 3 treated as logical |
| fill_sel | input | 2 | Logical fill: 0 zeros, 1 ones, 2 stream word, 3 treated as zeros |
| fill_stream | input | W | Stream bits for fill, lowest bit used first |
| dout | output | W | Registered result |

## Verification
The words used are:
- A walking one, which shows exactly where each bit lands for every amount.
- Alternating patterns, which expose swapped or off-by-one positions.
- Negative and positive words, which separate sign replication from constant fill.
- An all-zero data word with a distinct stream word, so that every one in the output must come from the fill path.

Amounts 0, 1, a middle value and n-1 are run in both directions and all modes. This distinguishes the left-to-right amount mapping from the masking of wrapped bits.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  typedef enum logic [1:0] {
    OP_LOGIC = 2'd0,
    OP_ARITH = 2'd1,
    OP_CIRC  = 2'd2,
    OP_RSVD  = 2'd3
  } shop_e;

  typedef enum logic [1:0] {
    FILL_ZERO   = 2'd0,
    FILL_ONE    = 2'd1,
    FILL_STREAM = 2'd2,
    FILL_RSVD   = 2'd3
  } fill_e;

endpackage

// File: rtl/shift_unit_rotr.sv
// Logarithmic right-rotate network: one 2:1 stage per amount bit.
module shift_unit_rotr #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [AW-1:0] r_i,
  output logic [W-1:0]  q_o
);

  logic [W-1:0] stage [AW+1];

  assign stage[0] = d_i;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = r_i[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]} : stage[k];
  end

  assign q_o = stage[AW];

endmodule

// File: rtl/shift_unit_fill.sv
// Builds the wrap mask and the per-bit fill value from the original amount.
module shift_unit_fill
  import shift_unit_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [AW-1:0] amt_i,
  input  logic          left_i,
  input  logic [1:0]    op_i,
  input  logic [1:0]    fsel_i,
  input  logic          sign_i,
  input  logic [W-1:0]  stream_i,
  input  logic [W-1:0]  stream_rot_i,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  fill_o
);

  shop_e op;
  fill_e fsel;

  assign op   = shop_e'(op_i);
  assign fsel = fill_e'(fsel_i);

  localparam logic [AW:0] WV = (AW+1)'(W);

  logic [AW:0] amt_x;
  assign amt_x = {1'b0, amt_i};

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [AW:0] IDX = (AW+1)'(i);
    logic hit_r;
    logic hit_l;
    logic fbit;

    // right: top m positions freed; left: bottom m positions freed
    assign hit_r = (IDX + amt_x) >= WV;
    assign hit_l = IDX < amt_x;

    always_comb begin
      unique case (op)
        OP_CIRC:  mask_o[i] = 1'b0;
        default:  mask_o[i] = left_i ? hit_l : hit_r;
      endcase
    end

    always_comb begin
      if (op == OP_ARITH) begin
        fbit = left_i ? 1'b0 : sign_i;
      end else begin
        unique case (fsel)
          FILL_ONE:    fbit = 1'b1;
          FILL_STREAM: fbit = left_i ? stream_i[i] : stream_rot_i[i];
          default:     fbit = 1'b0;
        endcase
      end
    end

    assign fill_o[i] = fbit;
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          dir_left,
  input  logic [1:0]    op_sel,
  input  logic [1:0]    fill_sel,
  input  logic [W-1:0]  fill_stream,
  output logic [W-1:0]  dout
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta;
  logic rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  // left by m becomes right by (n - m) mod n; m = 0 stays 0
  logic [AW-1:0] rot_amt;
  assign rot_amt = dir_left ? (AW'(0) - amt) : amt;

  logic [W-1:0] rot_data;
  logic [W-1:0] rot_stream;

  shift_unit_rotr #(.W(W), .AW(AW)) u_rot_data (
    .d_i (din),
    .r_i (rot_amt),
    .q_o (rot_data)
  );

  // stream placed so that its bit 0 lands on the lowest freed position of a right shift
  shift_unit_rotr #(.W(W), .AW(AW)) u_rot_stream (
    .d_i (fill_stream),
    .r_i (amt),
    .q_o (rot_stream)
  );

  logic [W-1:0] mask;
  logic [W-1:0] fillv;

  shift_unit_fill #(.W(W), .AW(AW)) u_fill (
    .amt_i        (amt),
    .left_i       (dir_left),
    .op_i         (op_sel),
    .fsel_i       (fill_sel),
    .sign_i       (din[W-1]),
    .stream_i     (fill_stream),
    .stream_rot_i (rot_stream),
    .mask_o       (mask),
    .fill_o       (fillv)
  );

  logic [W-1:0] dout_d;
  logic [W-1:0] dout_q;

  always_comb begin
    dout_d = (rot_data & ~mask) | (fillv & mask);
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      dout_q <= '0;
    end else begin
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_ok,
  input logic [W-1:0]  din,
  input logic [AW-1:0] amt,
  input logic          dir_left,
  input logic [1:0]    op_sel,
  input logic [1:0]    fill_sel,
  input logic [W-1:0]  dout
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_ok |-> dout == '0);  // R1

  AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (!rst_ok)
    (amt == '0) |=> dout == $past(din));  // R9

  AST_CIRC_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_sel == 2'd2) |=> $countones(dout) == $countones($past(din)));  // R8

  AST_ARITH_SIGN_HELD: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_sel == 2'd1 && !dir_left) |=> dout[W-1] == $past(din[W-1]));  // R6

  AST_ARITH_LEFT_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_sel == 2'd1 && dir_left && amt != '0) |=> dout[0] == 1'b0);  // R7

  AST_ONE_FILL_TOP: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_sel == 2'd0 && fill_sel == 2'd1 && !dir_left && amt != '0) |=> dout[W-1] == 1'b1);  // R3

endmodule

bind shift_unit shift_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .din      (din),
  .amt      (amt),
  .dir_left (dir_left),
  .op_sel   (op_sel),
  .fill_sel (fill_sel),
  .dout     (dout)
);

// File: tb/test_shift_unit.sv
`timescale 1ns/1ps
module test_shift_unit;

  localparam int W  = 32;
  localparam int AW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  din;
  logic [AW-1:0] amt;
  logic          dir_left;
  logic [1:0]    op_sel;
  logic [1:0]    fill_sel;
  logic [W-1:0]  fill_stream;
  logic [W-1:0]  dout;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shift_unit #(.W(W)) i_shift_unit (
    .clk, .rst_n, .din, .amt, .dir_left, .op_sel, .fill_sel, .fill_stream, .dout
  );

  // Expected result computed bit by bit from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int m, input bit lft,
                                         input int op, input int fs, input logic [W-1:0] st);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (op == 2) begin
        r[i] = lft ? d[(i - m + W) % W] : d[(i + m) % W];
      end else if (!lft) begin
        if (i + m < W)       r[i] = d[i + m];
        else if (op == 1)    r[i] = d[W-1];
        else if (fs == 1)    r[i] = 1'b1;
        else if (fs == 2)    r[i] = st[i - (W - m)];
        else                 r[i] = 1'b0;
      end else begin
        if (i >= m)          r[i] = d[i - m];
        else if (op == 1)    r[i] = 1'b0;
        else if (fs == 1)    r[i] = 1'b1;
        else if (fs == 2)    r[i] = st[i];
        else                 r[i] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic compare(input string req, input logic [W-1:0] exp);
    vectors++;
    if (dout !== exp) begin
      miscompares++;
      $display("FAIL %s: dout=%h expected=%h", req, dout, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [W-1:0] d, input int m, input bit lft,
                        input int op, input int fs, input logic [W-1:0] st);
    @(negedge clk);
    din = d; amt = AW'(m); dir_left = lft; op_sel = 2'(op); fill_sel = 2'(fs); fill_stream = st;
    @(posedge clk); #1;
    compare(req, model(d, m, lft, op, fs, st));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; din = '1; amt = '0; dir_left = 1'b0; op_sel = '0; fill_sel = '0; fill_stream = '0;
    repeat (3) @(posedge clk);
    #1 compare("R1 during reset", '0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after release", '0);
    repeat (2) @(posedge clk);
  endtask

  task automatic t_logical_right;
    run_op("R2 m=1",  32'h8000_0001, 1, 0, 0, 0, '0);
    run_op("R2 m=13", 32'hDEAD_BEEF, 13, 0, 0, 0, '1);
  endtask

  task automatic t_fill_one;
    run_op("R3 right", 32'h0000_00F0, 5, 0, 0, 1, '0);
    run_op("R3 left",  32'h0F00_0000, 7, 1, 0, 1, '0);
  endtask

  task automatic t_stream;
    run_op("R4 right stream", 32'h0, 9, 0, 0, 2, 32'h0000_0155);
    run_op("R4 right stream2", 32'h1234_5678, 4, 0, 0, 2, 32'hFFFF_FFF6);
  endtask

  task automatic t_left;
    run_op("R5 left zero",   32'hA5A5_A5A5, 3, 1, 0, 0, '1);
    run_op("R5 left stream", 32'h0, 11, 1, 0, 2, 32'h0000_02B3);
  endtask

  task automatic t_arith;
    run_op("R6 neg", 32'h8000_1230, 8, 0, 1, 1, '0);
    run_op("R6 pos", 32'h7000_1230, 8, 0, 1, 1, '1);
    run_op("R7 left fill1", 32'hFFFF_FFFF, 6, 1, 1, 1, '1);
    run_op("R7 left stream", 32'h0000_0003, 5, 1, 1, 2, '1);
  endtask

  task automatic t_circ;
    run_op("R8 right", 32'h0000_0001, 1, 0, 2, 1, '0);
    run_op("R8 left",  32'h8000_0000, 1, 1, 2, 1, '1);
    run_op("R8 mid",   32'hCAFE_0123, 17, 1, 2, 0, '0);
  endtask

  task automatic t_zero_amt;
    for (int op = 0; op < 4; op++) begin
      run_op("R9 right", 32'h9ABC_DEF0, 0, 0, op, 1, '1);
      run_op("R9 left",  32'h9ABC_DEF0, 0, 1, op, 2, '1);
    end
  endtask

  task automatic t_max_amt;
    for (int op = 0; op < 3; op++) begin
      run_op("R10 right", 32'h8000_0001, W-1, 0, op, 2, 32'h5555_5555);
      run_op("R10 left",  32'h8000_0001, W-1, 1, op, 1, 32'h5555_5555);
    end
    for (int m = 0; m < W; m++) run_op("R10 walk", 32'h0000_0100, m, m[0], 0, 0, '0);
  endtask

  task automatic t_reserved;
    run_op("R11 op3",   32'hF000_000F, 4, 0, 3, 1, '0);
    run_op("R11 fill3", 32'hF000_000F, 4, 1, 0, 3, '1);
  endtask

  task automatic t_latency;
    @(negedge clk);
    din = 32'h0000_FF00; amt = 5'd4; dir_left = 1'b0; op_sel = 2'd0; fill_sel = 2'd0; fill_stream = '0;
    @(negedge clk);
    compare("R12 first", 32'h0000_0FF0);
    din = 32'h0000_FF00; amt = 5'd4; dir_left = 1'b1;
    #4 compare("R12 held before edge", 32'h0000_0FF0);
    @(negedge clk);
    compare("R12 second", 32'h000F_F000);
  endtask

  initial begin
    t_reset();
    t_logical_right();
    t_fill_one();
    t_stream();
    t_left();
    t_arith();
    t_circ();
    t_zero_amt();
    t_max_amt();
    t_reserved();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule